// File: doc/BRIEF.md
# Opcode-Directed Instruction Field Decoder

This block sits between instruction fetch and execute. It captures a 53-bit instruction word whenever the fetch side marks it valid. One cycle later it presents a common decoded bundle together with a valid strobe. The 7-bit opcode in the top bits selects one of eight field layouts: no-operation, register-register, register-immediate, register-cache, cache-memory, world access, flow control and exception. The layout decides which register indices, which 32-bit immediate or jump target and which error code are taken from the word.

Opcodes that no layout claims are flagged as invalid, and the block supplies the bad-operation error code for them. Every decoded output depends only on the captured word. Any bit that the selected layout does not use reads back as zero on the outputs, so padding never leaks downstream.

Top module: `instr_fmt_decoder`

## Requirements
- R1: While reset is asserted, and in the first cycle after it, `validOut` is 0.
- R2: A word presented with `validIn`=1 at a rising edge appears decoded, with `validOut`=1, after that edge. When `validIn` is 0 at an edge, `validOut` falls to 0 and every decoded output keeps its previous value.
- R3: Opcode 0 gives format code 0 (no-operation), with all register indices, the immediate and the error code at zero and `badOpOut`=0.
- R4: Opcodes 1 to 51 give format code 1. The five register indices A..E are taken from bits [45:40], [39:34], [33:28], [27:22] and [21:16].
- R5: Opcodes 52 to 61 give format code 2. Index A is taken from [45:40] and the immediate from [39:8].
- R6: Opcodes 62 to 65 give format code 3, and opcodes 67 to 73 give format code 4. Both take indices A, B and C from [45:40], [39:34] and [33:28].
- R7: Opcodes 74 to 93 give format code 5. Indices A..D are taken from [45:40], [39:34], [33:28] and [27:22].
- R8: Opcodes 94 to 103 give format code 6. Index A is taken from [45:40], index B from [39:34] and the 32-bit target from [33:2].
- R9: Opcode 127 gives format code 7. The error code is taken from [45:40] and the handler address, on the immediate output, from [39:8]. `badOpOut` is 0.
- R10: Opcode 66 and opcodes 104 to 126 set `badOpOut`=1 and error code 0x05, with format code 0 and all indices and the immediate at zero.
- R11: Any index, immediate or error output that the selected format does not use is zero, whatever the other bits of the word hold.
- R12: `opcodeOut` equals bits [52:46] of the captured word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| validIn | input | 1 | Instruction word is valid this cycle |
| insnIn | input | 53 | Instruction word |
| validOut | output | 1 | Decoded bundle is valid |
| fmtOut | output | 3 | Format code 0..7 |
| opcodeOut | output | 7 | Captured opcode |
| regAOut | output | 6 | Register index A |
| regBOut | output | 6 | Register index B |
| regCOut | output | 6 | Register index C |
| regDOut | output | 6 | Register index D |
| regEOut | output | 6 | Register index E |
| immOut | output | 32 | Immediate, jump target or handler address |
| errOut | output | 6 | Error code |
| badOpOut | output | 1 | Opcode is not assigned to any format |

## Verification
The invalid-opcode flag and field extraction can act on the same word. A reserved opcode carries operand bits exactly where its neighbouring formats take their indices. The exception opcode puts its error-code field in the slot where the bad-operation code would otherwise be driven. The bench sweeps every one of the 128 opcodes under all-zero, all-one, alternating and pseudo-random operand bits. For each word it judges all outputs together against a model built from the requirement table. A mismatch in either function therefore shows up even when the other function is correct.

// File: rtl/instr_dec_pkg.sv
package instr_dec_pkg;

  typedef enum logic [2:0] {
    FMT_NOP  = 3'd0,
    FMT_RR   = 3'd1,
    FMT_RI   = 3'd2,
    FMT_RC   = 3'd3,
    FMT_CM   = 3'd4,
    FMT_WLD  = 3'd5,
    FMT_FLOW = 3'd6,
    FMT_EXC  = 3'd7
  } fmt_e;

  localparam int OP_RR_LO   = 1;
  localparam int OP_RR_HI   = 51;
  localparam int OP_RI_LO   = 52;
  localparam int OP_RI_HI   = 61;
  localparam int OP_RC_LO   = 62;
  localparam int OP_RC_HI   = 65;
  localparam int OP_CM_LO   = 67;
  localparam int OP_CM_HI   = 73;
  localparam int OP_WLD_LO  = 74;
  localparam int OP_WLD_HI  = 93;
  localparam int OP_FLOW_LO = 94;
  localparam int OP_FLOW_HI = 103;
  localparam int OP_EXC     = 127;

  localparam int NUM_IDX = 5;
  localparam logic [5:0] ERR_BAD_OP = 6'h05;

  // Strobes from control to datapath
  typedef struct packed {
    fmt_e               fmt;
    logic [NUM_IDX-1:0] regEn;     // bit i enables index field i (A..E)
    logic               immUpper;  // immediate from the field right after index A
    logic               immLower;  // immediate from the field right after index B
    logic               errField;  // error code from index A slot
    logic               badOp;
  } dec_strobe_t;

endpackage

// File: rtl/fmt_ctrl.sv
module fmt_ctrl
  import instr_dec_pkg::*;
#(
  parameter int OP_W = 7
) (
  input  logic [OP_W-1:0] opcode,
  output dec_strobe_t     strobe
);

  int opVal;

  always_comb begin
    opVal  = int'(opcode);
    strobe = '0;
    strobe.fmt = FMT_NOP;
    if (opVal == 0) begin
      strobe.fmt = FMT_NOP;
    end else if (opVal >= OP_RR_LO && opVal <= OP_RR_HI) begin
      strobe.fmt   = FMT_RR;
      strobe.regEn = 5'b11111;
    end else if (opVal >= OP_RI_LO && opVal <= OP_RI_HI) begin
      strobe.fmt      = FMT_RI;
      strobe.regEn    = 5'b00001;
      strobe.immUpper = 1'b1;
    end else if (opVal >= OP_RC_LO && opVal <= OP_RC_HI) begin
      strobe.fmt   = FMT_RC;
      strobe.regEn = 5'b00111;
    end else if (opVal >= OP_CM_LO && opVal <= OP_CM_HI) begin
      strobe.fmt   = FMT_CM;
      strobe.regEn = 5'b00111;
    end else if (opVal >= OP_WLD_LO && opVal <= OP_WLD_HI) begin
      strobe.fmt   = FMT_WLD;
      strobe.regEn = 5'b01111;
    end else if (opVal >= OP_FLOW_LO && opVal <= OP_FLOW_HI) begin
      strobe.fmt      = FMT_FLOW;
      strobe.regEn    = 5'b00011;
      strobe.immLower = 1'b1;
    end else if (opVal == OP_EXC) begin
      strobe.fmt      = FMT_EXC;
      strobe.errField = 1'b1;
      strobe.immUpper = 1'b1;
    end else begin
      strobe.badOp = 1'b1;  // reserved slot and unassigned tail
    end
  end

endmodule

// File: rtl/fmt_datapath.sv
module fmt_datapath
  import instr_dec_pkg::*;
#(
  parameter int WORD_W = 53,
  parameter int OP_W   = 7,
  parameter int IDX_W  = 6,
  parameter int IMM_W  = 32
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  logic                        validIn,
  input  logic [WORD_W-1:0]           insnIn,
  input  dec_strobe_t                 strobe,
  output logic                        validOut,
  output logic [OP_W-1:0]             opcodeOut,
  output logic [NUM_IDX-1:0][IDX_W-1:0] regOut,
  output logic [IMM_W-1:0]            immOut,
  output logic [IDX_W-1:0]            errOut,
  output logic [2:0]                  fmtOut,
  output logic                        badOpOut
);

  localparam int OP_LSB    = WORD_W - OP_W;
  localparam int FIELD_TOP = OP_LSB - 1;
  localparam int UP_TOP    = FIELD_TOP - IDX_W;
  localparam int LO_TOP    = FIELD_TOP - 2 * IDX_W;
  localparam int LO_LSB    = LO_TOP - IMM_W + 1;

  logic [WORD_W-1:0] insnQ;
  logic              validQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      insnQ  <= '0;
      validQ <= 1'b0;
    end else begin
      validQ <= validIn;
      if (validIn) insnQ <= insnIn;
    end
  end

  logic unusedLowPad;
  assign unusedLowPad = ^insnQ[LO_LSB-1:0];

  assign validOut  = validQ;
  assign opcodeOut = insnQ[WORD_W-1:OP_LSB];
  assign fmtOut    = strobe.fmt;
  assign badOpOut  = strobe.badOp;

  for (genvar i = 0; i < NUM_IDX; i++) begin : gIdx
    assign regOut[i] = strobe.regEn[i] ? insnQ[FIELD_TOP - i*IDX_W -: IDX_W] : '0;
  end

  always_comb begin
    immOut = '0;
    if (strobe.immUpper)      immOut = insnQ[UP_TOP -: IMM_W];
    else if (strobe.immLower) immOut = insnQ[LO_TOP -: IMM_W];
  end

  always_comb begin
    errOut = '0;
    if (strobe.badOp)         errOut = ERR_BAD_OP;
    else if (strobe.errField) errOut = insnQ[FIELD_TOP -: IDX_W];
  end

  AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (!rstN) validIn |=> validOut); // R2
  AST_IDLE_NO_VALID: assert property (@(posedge clk) disable iff (!rstN) !validIn |=> !validOut); // R2
  AST_HOLD_WORD: assert property (@(posedge clk) disable iff (!rstN) !validIn |=> $stable(opcodeOut) && $stable(immOut)); // R2
  AST_BADOP_QUIET: assert property (@(posedge clk) disable iff (!rstN) badOpOut |-> (regOut == '0) && (immOut == '0)); // R10
  AST_EXC_VALID: assert property (@(posedge clk) disable iff (!rstN) (opcodeOut == OP_W'(OP_EXC)) |-> (fmtOut == 3'd7) && !badOpOut); // R9
  AST_NOP_EMPTY: assert property (@(posedge clk) disable iff (!rstN) (opcodeOut == '0) |-> (regOut == '0) && (immOut == '0) && (errOut == '0)); // R3
  AST_IMM_ONE_SRC: assert property (@(posedge clk) disable iff (!rstN) $onehot0({strobe.immUpper, strobe.immLower, strobe.badOp})); // R11

endmodule

// File: rtl/instr_fmt_decoder.sv
module instr_fmt_decoder
  import instr_dec_pkg::*;
#(
  parameter int WORD_W = 53,
  parameter int OP_W   = 7,
  parameter int IDX_W  = 6,
  parameter int IMM_W  = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              validIn,
  input  logic [WORD_W-1:0] insnIn,
  output logic              validOut,
  output logic [2:0]        fmtOut,
  output logic [OP_W-1:0]   opcodeOut,
  output logic [IDX_W-1:0]  regAOut,
  output logic [IDX_W-1:0]  regBOut,
  output logic [IDX_W-1:0]  regCOut,
  output logic [IDX_W-1:0]  regDOut,
  output logic [IDX_W-1:0]  regEOut,
  output logic [IMM_W-1:0]  immOut,
  output logic [IDX_W-1:0]  errOut,
  output logic              badOpOut
);

  dec_strobe_t strobe;
  logic [NUM_IDX-1:0][IDX_W-1:0] regVec;

  fmt_ctrl #(.OP_W(OP_W)) uCtrl (
    .opcode (opcodeOut),
    .strobe (strobe)
  );

  fmt_datapath #(
    .WORD_W (WORD_W),
    .OP_W   (OP_W),
    .IDX_W  (IDX_W),
    .IMM_W  (IMM_W)
  ) uPath (
    .clk       (clk),
    .rstN      (rstN),
    .validIn   (validIn),
    .insnIn    (insnIn),
    .strobe    (strobe),
    .validOut  (validOut),
    .opcodeOut (opcodeOut),
    .regOut    (regVec),
    .immOut    (immOut),
    .errOut    (errOut),
    .fmtOut    (fmtOut),
    .badOpOut  (badOpOut)
  );

  assign regAOut = regVec[0];
  assign regBOut = regVec[1];
  assign regCOut = regVec[2];
  assign regDOut = regVec[3];
  assign regEOut = regVec[4];

endmodule

// File: tb/sim_instr_fmt_decoder.sv
`timescale 1ns/1ps
module sim_instr_fmt_decoder;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        validIn = 1'b0;
  logic [52:0] insnIn = '0;
  logic        validOut, badOpOut;
  logic [2:0]  fmtOut;
  logic [6:0]  opcodeOut;
  logic [5:0]  regAOut, regBOut, regCOut, regDOut, regEOut, errOut;
  logic [31:0] immOut;

  int testCount = 0;
  int failCount = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  instr_fmt_decoder u0 (
    .clk(clk), .rstN(rstN), .validIn(validIn), .insnIn(insnIn),
    .validOut(validOut), .fmtOut(fmtOut), .opcodeOut(opcodeOut),
    .regAOut(regAOut), .regBOut(regBOut), .regCOut(regCOut),
    .regDOut(regDOut), .regEOut(regEOut), .immOut(immOut),
    .errOut(errOut), .badOpOut(badOpOut)
  );

  // valid, fmt, opcode, A..E, imm, err, bad = 1+3+7+30+32+6+1 = 80 bits
  function automatic logic [79:0] model(input logic [52:0] w);
    int op = int'(w[52:46]);
    logic [2:0] f = 3'd0;
    logic [4:0] en = 5'b0;
    logic [31:0] imm = '0;
    logic [5:0] err = '0;
    logic bad = 1'b0;
    logic [5:0] a, b, c, d, e;
    if (op == 0) f = 3'd0;
    else if (op <= 51) begin f = 3'd1; en = 5'b11111; end
    else if (op <= 61) begin f = 3'd2; en = 5'b00001; imm = w[39:8]; end
    else if (op <= 65) begin f = 3'd3; en = 5'b00111; end
    else if (op == 66) begin bad = 1'b1; err = 6'h05; end
    else if (op <= 73) begin f = 3'd4; en = 5'b00111; end
    else if (op <= 93) begin f = 3'd5; en = 5'b01111; end
    else if (op <= 103) begin f = 3'd6; en = 5'b00011; imm = w[33:2]; end
    else if (op == 127) begin f = 3'd7; err = w[45:40]; imm = w[39:8]; end
    else begin bad = 1'b1; err = 6'h05; end
    a = en[0] ? w[45:40] : 6'd0;
    b = en[1] ? w[39:34] : 6'd0;
    c = en[2] ? w[33:28] : 6'd0;
    d = en[3] ? w[27:22] : 6'd0;
    e = en[4] ? w[21:16] : 6'd0;
    return {1'b1, f, w[52:46], a, b, c, d, e, imm, err, bad};
  endfunction

  function automatic string reqTag(input int op);
    if (op == 0) return "R3";
    if (op <= 51) return "R4";
    if (op <= 61) return "R5";
    if (op == 66 || (op >= 104 && op <= 126)) return "R10";
    if (op <= 73) return "R6";
    if (op <= 93) return "R7";
    if (op <= 103) return "R8";
    return "R9";
  endfunction

  function automatic logic [79:0] actual();
    return {validOut, fmtOut, opcodeOut, regAOut, regBOut, regCOut,
            regDOut, regEOut, immOut, errOut, badOpOut};
  endfunction

  task automatic check(input string tag, input logic [79:0] got, input logic [79:0] exp);
    testCount++;
    if (got !== exp) begin
      failCount++;
      $display("FAIL %s got=%h exp=%h", tag, got, exp);
    end
  endtask

  // drive at negedge, capture at next posedge, sample at following negedge
  task automatic applyWord(input logic [52:0] w);
    @(negedge clk);
    insnIn = w;
    validIn = 1'b1;
    @(negedge clk);
    validIn = 1'b0;
    check(reqTag(int'(w[52:46])), actual(), model(w));  // R4..R10, R11, R12
  endtask

  initial begin
    logic [63:0] rng = 64'h9E37_79B9_7F4A_7C15;
    logic [45:0] pats[4];
    logic [79:0] lastExp;
    pats[0] = '0;
    pats[1] = '1;
    pats[2] = 46'h2AAA_AAAA_AAAA;
    pats[3] = 46'h1555_5555_5555;

    repeat (3) @(negedge clk);
    check("R1 reset", {79'd0, validOut}, 80'd0);
    @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check("R1 post-reset", {79'd0, validOut}, 80'd0);

    // R3..R12 sweep of all opcodes under fixed patterns (padding all-ones covers R11)
    for (int p = 0; p < 4; p++) begin
      for (int op = 0; op < 128; op++) begin
        applyWord({7'(op), pats[p]});
      end
    end
    // pseudo-random operands
    for (int op = 0; op < 128; op++) begin
      rng = rng ^ (rng << 13); rng = rng ^ (rng >> 7); rng = rng ^ (rng << 17);
      applyWord({7'(op), rng[45:0]});
    end

    // R2: back-to-back valid words
    @(negedge clk);
    insnIn = {7'd3, 46'h0123_4567_89AB};
    validIn = 1'b1;
    @(negedge clk);
    check("R2 b2b first", actual(), model({7'd3, 46'h0123_4567_89AB}));
    insnIn = {7'd127, 46'h3FED_CBA9_8765};
    @(negedge clk);
    validIn = 1'b0;
    lastExp = model({7'd127, 46'h3FED_CBA9_8765});
    check("R2 b2b second", actual(), lastExp);

    // R2: word ignored while validIn low, outputs hold
    insnIn = {7'd55, 46'h1111_2222_3333};
    @(negedge clk);
    check("R2 hold valid", {79'd0, validOut}, 80'd0);
    check("R2 hold fields", {1'b1, actual()[78:0]}, lastExp);
    @(negedge clk);
    check("R2 hold fields again", {1'b1, actual()[78:0]}, lastExp);

    // R11: padding-only difference gives identical decode for an immediate word
    applyWord({7'd55, 6'd9, 32'hDEAD_BEEF, 8'h00});
    check("R11 pad", actual(), model({7'd55, 6'd9, 32'hDEAD_BEEF, 8'hFF}));

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", testCount, failCount);
    $finish;
  end

  initial begin
    #500000;
    if (!done) begin
      testCount++;
      failCount++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", testCount, failCount);
      $finish;
    end
  end

endmodule